// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block watches write-class completions retiring from a data cache and keeps the lock reservations that load-linked and store-conditional pairs depend on. Each completion carries a line address, an operation kind and a requester id. A load-linked completion reserves its line for that requester. A store-conditional is judged against the table: it succeeds only when the reserving requester is the one asking. Whatever the outcome, the store-conditional then drops the reservation on its line. Plain stores, and both halves of a read-modify-write pair, drop a reservation that their own requester holds. Loads and instruction fetches leave the table alone.

Reservations sit in a small table of entries. Each entry holds a valid bit, a line address and an owner id. A load-linked to a line that is already reserved retags that entry and makes it the youngest. When the table is full, a load-linked to a new line takes the slot of the oldest reservation. The block also tells the cache controller when to freeze and when to release the request queue for one address. The first half of a read-modify-write raises a block pulse. The second half raises an unblock pulse. Every completion gets exactly one registered reply one cycle after it is accepted.

The reply path is a two-state machine. RP_IDLE means no reply is being presented. RP_SEND means a reply is on the outputs this cycle. The transitions are as follows. An accepted completion moves RP_IDLE to RP_SEND, and it also holds RP_SEND when completions arrive back to back. A cycle with no completion moves RP_SEND back to RP_IDLE, and it keeps RP_IDLE where it is.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reply or queue pulse is presented and the table holds no reservation, so a store-conditional issued right after reset reports failure.
- R2: A store-conditional (kind 6) to a line reserved by the same requester id reports rsp_ok = 1.
- R3: A store-conditional to a line that is unreserved, or that is reserved by a different requester id, reports rsp_ok = 0.
- R4: Every store-conditional removes the reservation on its line, whether it succeeds or fails, and whoever owns it.
- R5: A plain store (kind 2), an RMW-read (kind 3) or an RMW-write (kind 4) removes a reservation on its line only when the issuing requester owns it; a different requester's write leaves it in place.
- R6: A load (kind 0), an instruction fetch (kind 1) and the spare code (kind 7) change no reservation and report rsp_ok = 1.
- R7: A load-linked (kind 5) always reports rsp_ok = 1 and reserves its line for its requester; a load-linked to a line that is already reserved hands that reservation to the new requester.
- R8: When all entries are valid, a load-linked to an unreserved line evicts the reservation that was set or refreshed least recently.
- R9: An RMW-read produces qblk_set = 1 and an RMW-write produces qblk_clr = 1 with qblk_line equal to the completion's line, in the reply cycle; no other kind raises either pulse.
- R10: rsp_valid is high in exactly the cycle after each accepted completion (cmp_valid high at a clock edge), including back-to-back completions, and low otherwise.
- R11: A slot freed by a clear is reused by the next load-linked to a new line without evicting any live reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | A completion is presented this cycle |
| cmp_kind | input | 3 | Operation kind: 0 load, 1 fetch, 2 store, 3 RMW-read, 4 RMW-write, 5 load-linked, 6 store-conditional, 7 spare |
| cmp_line | input | AW | Line address of the completion |
| cmp_owner | input | IW | Requester id |
| rsp_valid | output | 1 | Reply cycle for the completion accepted on the previous edge |
| rsp_ok | output | 1 | Success flag (1 success, 0 failed store-conditional) |
| qblk_set | output | 1 | Freeze the controller request queue for qblk_line |
| qblk_clr | output | 1 | Release the controller request queue for qblk_line |
| qblk_line | output | AW | Address that the block or release applies to |

## Verification
The bench builds the block with two entries, 8-bit line addresses and 2-bit requester ids. With only two slots, the full-table case is reached after two load-linked operations. Because of that, the eviction of the oldest reservation, the refresh that rescues an entry from eviction, and the reuse of a freed slot each take only a handful of completions. Four requester ids are enough to pit an owner against foreign store-conditionals and foreign stores on the same line.

// File: rtl/llsc_mon_pkg.sv
package llsc_mon_pkg;

    typedef enum logic [2:0] {
        K_LOAD   = 3'd0,
        K_IFETCH = 3'd1,
        K_STORE  = 3'd2,
        K_RMW_RD = 3'd3,
        K_RMW_WR = 3'd4,
        K_LL     = 3'd5,
        K_SC     = 3'd6,
        K_SPARE  = 3'd7
    } cmp_kind_e;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_SEND = 1'b1
    } reply_state_e;

    typedef struct packed {
        logic set_resv;
        logic cond_store;
        logic own_clear;
        logic q_block;
        logic q_unblock;
    } kind_ctl_t;

endpackage

// File: rtl/llsc_kind_decode.sv
module llsc_kind_decode
    import llsc_mon_pkg::*;
(
    input  logic [2:0] kind,
    output kind_ctl_t  ctl
);

    cmp_kind_e kind_e;

    always_comb begin
        kind_e = cmp_kind_e'(kind);
        ctl    = '0;
        unique case (kind_e)
            K_LL:     ctl.set_resv   = 1'b1;
            K_SC:     ctl.cond_store = 1'b1;
            K_STORE:  ctl.own_clear  = 1'b1;
            K_RMW_RD: begin
                ctl.own_clear = 1'b1;
                ctl.q_block   = 1'b1;
            end
            K_RMW_WR: begin
                ctl.own_clear = 1'b1;
                ctl.q_unblock = 1'b1;
            end
            K_LOAD, K_IFETCH, K_SPARE: ctl = '0;
        endcase
    end

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
    parameter int ENTRIES = 4,
    parameter int AW      = 26,
    parameter int IW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          set_req,
    input  logic          sc_req,
    input  logic          wclr_req,
    input  logic [AW-1:0] line,
    input  logic [IW-1:0] owner,
    output logic          held_by_owner
);

    localparam int RW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [RW-1:0] LAST_RANK = RW'(ENTRIES - 1);
    localparam logic [RW:0]   NEW_RANK  = (RW + 1)'(ENTRIES);

    logic [ENTRIES-1:0] vld_q;
    logic [AW-1:0]      line_q [ENTRIES];
    logic [IW-1:0]      own_q  [ENTRIES];
    logic [RW-1:0]      rank_q [ENTRIES];

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] mine_vec;
    logic [ENTRIES-1:0] clr_vec;
    logic               table_full;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g]  = vld_q[g] && (line_q[g] == line);
            assign mine_vec[g] = hit_vec[g] && (own_q[g] == owner);
        end
    endgenerate

    assign table_full    = &vld_q;
    assign held_by_owner = |mine_vec;
    assign clr_vec       = sc_req ? hit_vec : (wclr_req ? mine_vec : '0);

    logic          hit_any;
    logic [RW-1:0] hit_idx;
    logic [RW-1:0] free_idx;
    logic [RW-1:0] victim_idx;
    logic [RW-1:0] tgt_idx;
    logic [RW:0]   old_rank;
    logic          clr_any;
    logic [RW-1:0] clr_idx;
    logic [RW-1:0] clr_rank;

    always_comb begin
        hit_any    = 1'b0;
        hit_idx    = '0;
        free_idx   = '0;
        victim_idx = '0;
        clr_any    = 1'b0;
        clr_idx    = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = RW'(i);
            end
            if (!vld_q[i]) begin
                free_idx = RW'(i);
            end
            if (vld_q[i] && (rank_q[i] == LAST_RANK)) begin
                victim_idx = RW'(i);
            end
            if (clr_vec[i]) begin
                clr_any = 1'b1;
                clr_idx = RW'(i);
            end
        end
        clr_rank = rank_q[clr_idx];
        if (hit_any) begin
            tgt_idx  = hit_idx;
            old_rank = {1'b0, rank_q[hit_idx]};
        end else if (!table_full) begin
            tgt_idx  = free_idx;
            old_rank = NEW_RANK;
        end else begin
            tgt_idx  = victim_idx;
            old_rank = {1'b0, LAST_RANK};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                line_q[i] <= '0;
                own_q[i]  <= '0;
                rank_q[i] <= '0;
            end
        end else if (op_valid) begin
            if (set_req) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (RW'(i) == tgt_idx) begin
                        vld_q[i]  <= 1'b1;
                        line_q[i] <= line;
                        own_q[i]  <= owner;
                        rank_q[i] <= '0;
                    end else if (vld_q[i] && ({1'b0, rank_q[i]} < old_rank)) begin
                        rank_q[i] <= rank_q[i] + 1'b1;
                    end
                end
            end else if (clr_any) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (RW'(i) == clr_idx) begin
                        vld_q[i] <= 1'b0;
                    end else if (vld_q[i] && (rank_q[i] > clr_rank)) begin
                        rank_q[i] <= rank_q[i] - 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/llsc_reply_fsm.sv
module llsc_reply_fsm
    import llsc_mon_pkg::*;
#(
    parameter int AW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          ok_in,
    input  logic          blk_in,
    input  logic          unblk_in,
    input  logic [AW-1:0] line_in,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic          qblk_set,
    output logic          qblk_clr,
    output logic [AW-1:0] qblk_line
);

    reply_state_e state_q, state_d;
    logic          ok_q;
    logic          blk_q;
    logic          unblk_q;
    logic [AW-1:0] line_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: state_d = accept ? RP_SEND : RP_IDLE;
            RP_SEND: state_d = accept ? RP_SEND : RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q    <= 1'b0;
            blk_q   <= 1'b0;
            unblk_q <= 1'b0;
            line_q  <= '0;
        end else if (accept) begin
            ok_q    <= ok_in;
            blk_q   <= blk_in;
            unblk_q <= unblk_in;
            line_q  <= line_in;
        end
    end

    always_comb begin
        rsp_valid = (state_q == RP_SEND);
        rsp_ok    = rsp_valid && ok_q;
        qblk_set  = rsp_valid && blk_q;
        qblk_clr  = rsp_valid && unblk_q;
        qblk_line = line_q;
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_mon_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 26,
    parameter int IW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_valid,
    input  logic [2:0]    cmp_kind,
    input  logic [AW-1:0] cmp_line,
    input  logic [IW-1:0] cmp_owner,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic          qblk_set,
    output logic          qblk_clr,
    output logic [AW-1:0] qblk_line
);

    kind_ctl_t ctl;
    logic      held;
    logic      ok_now;

    llsc_kind_decode u_dec (
        .kind (cmp_kind),
        .ctl  (ctl)
    );

    llsc_resv_table #(
        .ENTRIES (ENTRIES),
        .AW      (AW),
        .IW      (IW)
    ) u_tab (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (cmp_valid),
        .set_req       (ctl.set_resv),
        .sc_req        (ctl.cond_store),
        .wclr_req      (ctl.own_clear),
        .line          (cmp_line),
        .owner         (cmp_owner),
        .held_by_owner (held)
    );

    // Only a conditional store can fail; every other kind reports success.
    assign ok_now = ctl.cond_store ? held : 1'b1;

    llsc_reply_fsm #(
        .AW (AW)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (cmp_valid),
        .ok_in     (ok_now),
        .blk_in    (ctl.q_block),
        .unblk_in  (ctl.q_unblock),
        .line_in   (cmp_line),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .qblk_set  (qblk_set),
        .qblk_clr  (qblk_clr),
        .qblk_line (qblk_line)
    );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int AW = 26,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmp_valid,
    input logic [2:0]    cmp_kind,
    input logic [AW-1:0] cmp_line,
    input logic [IW-1:0] cmp_owner,
    input logic          rsp_valid,
    input logic          rsp_ok,
    input logic          qblk_set,
    input logic          qblk_clr,
    input logic [AW-1:0] qblk_line
);

    // R10
    reply_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> rsp_valid);

    // R10
    no_spurious_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !rsp_valid);

    // R9
    block_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd3) |=> (qblk_set && !qblk_clr && qblk_line == $past(cmp_line)));

    // R9
    unblock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd4) |=> (qblk_clr && !qblk_set && qblk_line == $past(cmp_line)));

    // R9
    pulse_only_in_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qblk_set || qblk_clr) |-> rsp_valid);

    // R7
    ll_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd5) |=> rsp_ok);

    // R6
    read_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && (cmp_kind == 3'd0 || cmp_kind == 3'd1 || cmp_kind == 3'd7)) |=> (rsp_ok && !qblk_set && !qblk_clr));

    // R1
    quiet_reset_chk: assert property (@(posedge clk)
        !rst_n |-> (!rsp_valid && !qblk_set && !qblk_clr));

    logic unused_owner;
    assign unused_owner = ^cmp_owner;

endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_kind  (cmp_kind),
    .cmp_line  (cmp_line),
    .cmp_owner (cmp_owner),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .qblk_set  (qblk_set),
    .qblk_clr  (qblk_clr),
    .qblk_line (qblk_line)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;

    localparam int ENTRIES = 2;
    localparam int AW      = 8;
    localparam int IW      = 2;
    localparam int NV      = 46;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_valid = 1'b0;
    logic [2:0]    cmp_kind = 3'd0;
    logic [AW-1:0] cmp_line = '0;
    logic [IW-1:0] cmp_owner = '0;
    logic          rsp_valid, rsp_ok, qblk_set, qblk_clr;
    logic [AW-1:0] qblk_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    llsc_monitor #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_llsc_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .cmp_kind  (cmp_kind),
        .cmp_line  (cmp_line),
        .cmp_owner (cmp_owner),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .qblk_set  (qblk_set),
        .qblk_clr  (qblk_clr),
        .qblk_line (qblk_line)
    );

    // Vector fields: [19:16] requirement, [15:13] kind, [12:5] line,
    // [4:3] owner, [2] expected ok, [1] expected block, [0] expected unblock.
    // Kinds: 0 load, 1 fetch, 2 store, 3 rmw-rd, 4 rmw-wr, 5 LL, 6 SC, 7 spare.
    localparam logic [19:0] VEC [NV] = '{
        {4'd7,  3'd5, 8'h10, 2'd1, 3'b100},  // R7 LL reserves
        {4'd2,  3'd6, 8'h10, 2'd1, 3'b100},  // R2 owner SC succeeds
        {4'd4,  3'd6, 8'h10, 2'd1, 3'b000},  // R4 reservation gone
        {4'd7,  3'd5, 8'h20, 2'd2, 3'b100},
        {4'd3,  3'd6, 8'h20, 2'd3, 3'b000},  // R3 foreign SC fails
        {4'd4,  3'd6, 8'h20, 2'd2, 3'b000},  // R4 failed SC cleared it
        {4'd7,  3'd5, 8'h30, 2'd0, 3'b100},
        {4'd5,  3'd2, 8'h30, 2'd1, 3'b100},  // R5 foreign store
        {4'd5,  3'd6, 8'h30, 2'd0, 3'b100},  // R5 reservation survived
        {4'd7,  3'd5, 8'h40, 2'd2, 3'b100},
        {4'd5,  3'd2, 8'h40, 2'd2, 3'b100},  // R5 own store
        {4'd5,  3'd6, 8'h40, 2'd2, 3'b000},  // R5 reservation cleared
        {4'd7,  3'd5, 8'h50, 2'd1, 3'b100},
        {4'd6,  3'd0, 8'h50, 2'd1, 3'b100},  // R6 load
        {4'd6,  3'd1, 8'h50, 2'd2, 3'b100},  // R6 fetch
        {4'd6,  3'd6, 8'h50, 2'd1, 3'b100},  // R6 untouched
        {4'd9,  3'd3, 8'h60, 2'd0, 3'b110},  // R9 block
        {4'd9,  3'd4, 8'h60, 2'd0, 3'b101},  // R9 unblock
        {4'd7,  3'd5, 8'h70, 2'd1, 3'b100},
        {4'd9,  3'd3, 8'h70, 2'd1, 3'b110},
        {4'd9,  3'd4, 8'h70, 2'd1, 3'b101},
        {4'd5,  3'd6, 8'h70, 2'd1, 3'b000},  // R5 rmw cleared
        {4'd8,  3'd5, 8'h11, 2'd0, 3'b100},
        {4'd8,  3'd5, 8'h12, 2'd1, 3'b100},
        {4'd8,  3'd5, 8'h13, 2'd2, 3'b100},  // R8 evicts 0x11
        {4'd8,  3'd6, 8'h11, 2'd0, 3'b000},
        {4'd8,  3'd6, 8'h12, 2'd1, 3'b100},
        {4'd8,  3'd5, 8'h14, 2'd3, 3'b100},
        {4'd8,  3'd5, 8'h13, 2'd2, 3'b100},  // R8 refresh
        {4'd8,  3'd5, 8'h15, 2'd0, 3'b100},  // R8 evicts 0x14
        {4'd8,  3'd6, 8'h14, 2'd3, 3'b000},
        {4'd8,  3'd6, 8'h13, 2'd2, 3'b100},
        {4'd8,  3'd6, 8'h15, 2'd0, 3'b100},
        {4'd7,  3'd5, 8'h21, 2'd1, 3'b100},
        {4'd7,  3'd5, 8'h21, 2'd2, 3'b100},  // R7 retag
        {4'd7,  3'd6, 8'h21, 2'd1, 3'b000},
        {4'd4,  3'd6, 8'h21, 2'd2, 3'b000},
        {4'd11, 3'd5, 8'h31, 2'd0, 3'b100},
        {4'd11, 3'd5, 8'h32, 2'd1, 3'b100},
        {4'd11, 3'd6, 8'h31, 2'd0, 3'b100},
        {4'd11, 3'd5, 8'h33, 2'd2, 3'b100},  // R11 free slot
        {4'd11, 3'd6, 8'h32, 2'd1, 3'b100},
        {4'd11, 3'd6, 8'h33, 2'd2, 3'b100},
        {4'd6,  3'd5, 8'h41, 2'd3, 3'b100},
        {4'd6,  3'd7, 8'h41, 2'd3, 3'b100},  // R6 spare code
        {4'd6,  3'd6, 8'h41, 2'd3, 3'b100}
    };

    task automatic check(input string req, input logic [AW+3:0] got, input logic [AW+3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid/ok/set/clr/line=%h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] k, input logic [AW-1:0] l, input logic [IW-1:0] o);
        cmp_valid = 1'b1;
        cmp_kind  = k;
        cmp_line  = l;
        cmp_owner = o;
    endtask

    task automatic idle();
        cmp_valid = 1'b0;
    endtask

    function automatic logic [AW+3:0] outs();
        return {rsp_valid, rsp_ok, qblk_set, qblk_clr, qblk_line};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [AW-1:0] exp_line;
        repeat (3) @(negedge clk);
        // R1 outputs quiet in reset
        check("R1", outs(), {4'b0000, {AW{1'b0}}});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), {4'b0000, {AW{1'b0}}});
        // R1 empty table: SC fails
        drive(3'd6, 8'h10, 2'd1);
        @(negedge clk);
        idle();
        check("R1", outs(), {4'b1000, 8'h10});

        // Vector table, back to back
        drive(VEC[0][15:13], VEC[0][12:5], VEC[0][4:3]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            exp_line = (VEC[i][1] || VEC[i][0]) ? VEC[i][12:5] : qblk_line;
            check($sformatf("R%0d vec%0d", VEC[i][19:16], i),
                  {rsp_valid, rsp_ok, qblk_set, qblk_clr, qblk_line},
                  {1'b1, VEC[i][2:0], exp_line});
            if (i + 1 < NV) drive(VEC[i+1][15:13], VEC[i+1][12:5], VEC[i+1][4:3]);
            else idle();
        end

        // R10 idle cycles give no reply
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10", {3'b000, rsp_valid}, 4'b0000);
        end

        // R10 single gap: reply, then silence
        drive(3'd0, 8'h99, 2'd0);
        @(negedge clk);
        idle();
        check("R10", {3'b000, rsp_valid}, 4'b0001);
        @(negedge clk);
        check("R10", {3'b000, rsp_valid}, 4'b0000);

        // R1 reset wipes reservations
        drive(3'd5, 8'h55, 2'd1);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", outs(), {4'b0000, {AW{1'b0}}});
        rst_n = 1'b1;
        @(negedge clk);
        drive(3'd6, 8'h55, 2'd1);
        @(negedge clk);
        idle();
        check("R1", outs(), {4'b1000, 8'h55});
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule